// File: doc/BRIEF.md
# Arithmetic Condition Flag Updater

This block produces the next value of a status word after an ALU or multiply operation that asks for its flags to be set. The datapath supplies the two operands, the result it has already computed, an operation class, the shifter carry-out, the current status word and the saved status word. For long multiply, the datapath also supplies the upper half of the product. The block does no arithmetic of its own. From these inputs it works out negative, zero, carry and overflow. The flags sit in the four top bits of the status word, in the order N, Z, C, V from the most significant bit down. Each operation class leaves a different subset of those flags unchanged. The lower bits of the word are always carried over.

There is one exception to the flag calculation. When a flag-setting operation writes the program counter and the current mode has a saved status word, the block loads that saved word whole and raises a restore strobe. No flags are calculated in that case.

The control is a three-state machine, registered once. ST_IDLE means no operation was accepted in the last cycle. ST_FLAGS means a flag update was written. ST_RESTORE means the saved word was loaded. Every cycle the next state is picked from the inputs. The transition take_idle fires when op_valid is low. The transition take_restore fires when op_valid, dest_pc and has_saved are all high. The transition take_flags fires when op_valid is high in any other case. Any state can reach any other state. All results appear one clock after the operation is presented.

Top module: `cond_flag_updater`

## Requirements
- R1: After reset, status_out is zero and upd_valid, restore_pulse and reg_we are all low.
- R2: For class 0 (add) and class 1 (add with carry), one cycle after op_valid: N is result[W-1] and Z is 1 exactly when result is zero. C is the unsigned carry out of opnd_a + opnd_b + carry-in. V is the signed overflow of that sum.
- R3: For class 2 (subtract opnd_a minus opnd_b) and class 3 (subtract with borrow, where the borrow is the inverse of the current C): N and Z come from result. C is 1 when no borrow occurs. V is the signed overflow of the subtraction. A reverse subtract is presented with the operands swapped.
- R4: For class 4 (logical or move), N and Z come from result, C takes shift_carry, and V keeps its current value.
- R5: For class 5 (single-width multiply), N and Z come from result, and C and V keep their current values.
- R6: For class 6 (long multiply), N is prod_hi[W-1], Z is 1 only when prod_hi and result are both zero, and C and V keep their current values.
- R7: When op_valid, dest_pc and has_saved are all high, status_out becomes saved_status whole and restore_pulse is high for that cycle. When dest_pc is high but has_saved is low, a normal flag update takes place.
- R8: On a flag update, the bits of status_out below the four flag bits equal the same bits of cur_status.
- R9: upd_valid is high one cycle after each accepted operation. In that cycle reg_we is high unless cmp_only was set, which marks a compare or test.
- R10: While op_valid is low, status_out holds its value and upd_valid, restore_pulse and reg_we are all low.
- R11: Class code 7 leaves all four flags at their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A flag-setting operation is presented |
| op_class | input | 3 | Operation class code (0 to 7) |
| cmp_only | input | 1 | The operation is a compare or test and writes no register |
| dest_pc | input | 1 | The destination register is the program counter |
| has_saved | input | 1 | The current mode owns a saved status word |
| opnd_a | input | W | First operand, or the minuend |
| opnd_b | input | W | Second operand, or the subtrahend |
| result | input | W | Operation result, or the low product half |
| prod_hi | input | W | High product half for long multiply |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| cur_status | input | W | Current status word |
| saved_status | input | W | Saved status word |
| status_out | output | W | New status word |
| restore_pulse | output | 1 | The saved word was loaded in this cycle |
| upd_valid | output | 1 | status_out was updated in this cycle |
| reg_we | output | 1 | The operation may write its destination register |

## Verification
The hardest cases to reach are the edges where carry and overflow meet a zero result. One example is an add with carry-in that wraps to exactly zero, which must set both Z and C. Another is a subtract with borrow whose only borrow comes from the inverted current C. The bench reaches these by sweeping every pair of operands in a 6-bit build, through every add and subtract class and both carry inputs. It computes the reference values with plain integer arithmetic in a wider range. The restore path is driven on purpose with result values whose flags are plainly wrong, so that any calculated flags leaking into the restored word would show up.

// File: rtl/flagupd_pkg.sv
package flagupd_pkg;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_ADC   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_SBC   = 3'd3,
        OPC_LOGIC = 3'd4,
        OPC_MUL   = 3'd5,
        OPC_LMUL  = 3'd6,
        OPC_NONE  = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FLAGS   = 2'd1,
        ST_RESTORE = 2'd2
    } st_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int NFLAGS = 4;

endpackage

// File: rtl/fu_arith.sv
// Carry and overflow recovered from operands and a result computed elsewhere.
// The formulas hold for any carry-in, so the with-carry classes need no extra input.
module fu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         is_sub,
    output logic         carry,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W-1:0] gen_t;

    always_comb begin
        // A subtraction is an addition of the inverted subtrahend.
        b_eff = is_sub ? ~b : b;
        gen_t = (a & b_eff) | ((a | b_eff) & ~r);
        carry = gen_t[MSB];
        ovf   = (a[MSB] == b_eff[MSB]) && (r[MSB] != a[MSB]);
    end
endmodule

// File: rtl/fu_select.sv
module fu_select
    import flagupd_pkg::*;
#(
    parameter int W = 32
) (
    input  opc_e         cls,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic [W-1:0] hi,
    input  logic         shc,
    input  logic [W-1:0] cur,
    output logic [W-1:0] word_nx
);
    localparam int LOWW = W - NFLAGS;

    nzcv_t cur_f;
    nzcv_t f;
    logic  ar_c;
    logic  ar_v;
    logic  r_zero;
    logic  hi_zero;
    logic  sub_sel;

    assign cur_f   = cur[W-1 -: NFLAGS];
    assign r_zero  = ~|r;
    assign hi_zero = ~|hi;
    assign sub_sel = (cls == OPC_SUB) || (cls == OPC_SBC);

    fu_arith #(.W(W)) u_arith (
        .a      (a),
        .b      (b),
        .r      (r),
        .is_sub (sub_sel),
        .carry  (ar_c),
        .ovf    (ar_v)
    );

    always_comb begin
        f = cur_f;
        unique case (cls)
            OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBC: begin
                f.n = r[W-1];
                f.z = r_zero;
                f.c = ar_c;
                f.v = ar_v;
            end
            OPC_LOGIC: begin
                f.n = r[W-1];
                f.z = r_zero;
                f.c = shc;
            end
            OPC_MUL: begin
                f.n = r[W-1];
                f.z = r_zero;
            end
            OPC_LMUL: begin
                f.n = hi[W-1];
                f.z = r_zero & hi_zero;
            end
            OPC_NONE: begin
                f = cur_f;
            end
        endcase
    end

    generate
        if (LOWW > 0) begin : g_low
            assign word_nx = {f, cur[LOWW-1:0]};
        end else begin : g_nolow
            assign word_nx = f;
        end
    endgenerate
endmodule

// File: rtl/cond_flag_updater.sv
module cond_flag_updater
    import flagupd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_class,
    input  logic         cmp_only,
    input  logic         dest_pc,
    input  logic         has_saved,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] result,
    input  logic [W-1:0] prod_hi,
    input  logic         shift_carry,
    input  logic [W-1:0] cur_status,
    input  logic [W-1:0] saved_status,
    output logic [W-1:0] status_out,
    output logic         restore_pulse,
    output logic         upd_valid,
    output logic         reg_we
);
    localparam int LOWW = W - NFLAGS;
    localparam int POSC = W - 3;
    localparam int POSV = W - 4;

    st_e          state_q;
    st_e          state_nx;
    logic [W-1:0] word_nx;

    fu_select #(.W(W)) u_sel (
        .cls     (opc_e'(op_class)),
        .a       (opnd_a),
        .b       (opnd_b),
        .r       (result),
        .hi      (prod_hi),
        .shc     (shift_carry),
        .cur     (cur_status),
        .word_nx (word_nx)
    );

    // take_idle / take_restore / take_flags
    always_comb begin
        if (!op_valid)
            state_nx = ST_IDLE;
        else if (dest_pc && has_saved)
            state_nx = ST_RESTORE;
        else
            state_nx = ST_FLAGS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_out <= '0;
            reg_we     <= 1'b0;
        end else begin
            unique case (state_nx)
                ST_IDLE: begin
                    reg_we <= 1'b0;
                end
                ST_FLAGS: begin
                    status_out <= word_nx;
                    reg_we     <= ~cmp_only;
                end
                ST_RESTORE: begin
                    status_out <= saved_status;
                    reg_we     <= ~cmp_only;
                end
                default: begin
                    reg_we <= 1'b0;
                end
            endcase
        end
    end

    assign restore_pulse = (state_q == ST_RESTORE);
    assign upd_valid     = (state_q != ST_IDLE);

    // R7: the restored word is the saved word unchanged
    a_r7_restore_word: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |-> status_out == $past(saved_status));

    // R4: logical class keeps V
    a_r4_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAGS && $past(op_class) == 3'd4)
            |-> status_out[POSV] == $past(cur_status[POSV]));

    // R6: long multiply keeps C and V
    a_r6_lmul_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAGS && $past(op_class) == 3'd6)
            |-> status_out[POSC:POSV] == $past(cur_status[POSC:POSV]));

    // R9: compare and test never enable a register write
    a_r9_cmp_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(cmp_only)) |-> !reg_we);

    // R10: an idle cycle leaves the word untouched
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> ($stable(status_out) && !reg_we));

    generate
        if (LOWW > 0) begin : g_lowchk
            // R8: low bits copied from the current word
            a_r8_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_FLAGS)
                    |-> status_out[LOWW-1:0] == $past(cur_status[LOWW-1:0]));
        end
    endgenerate
endmodule

// File: tb/tb_cond_flag_updater.sv
module tb_cond_flag_updater;
    localparam int W = 6;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [2:0]   op_class;
    logic         cmp_only;
    logic         dest_pc;
    logic         has_saved;
    logic [W-1:0] opnd_a, opnd_b, result, prod_hi;
    logic         shift_carry;
    logic [W-1:0] cur_status, saved_status;
    logic [W-1:0] status_out;
    logic         restore_pulse, upd_valid, reg_we;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [W-1:0] last_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_updater #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .cmp_only(cmp_only), .dest_pc(dest_pc), .has_saved(has_saved),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .prod_hi(prod_hi),
        .shift_carry(shift_carry), .cur_status(cur_status),
        .saved_status(saved_status), .status_out(status_out),
        .restore_pulse(restore_pulse), .upd_valid(upd_valid), .reg_we(reg_we)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [W+2:0] got, input logic [W+2:0] exp);
        n_run = n_run + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual={word,upd,rst,we}=%b expected=%b", tag, got, exp);
        end
    endtask

    // Called at a falling edge; drives the inputs, then checks at the next falling edge.
    task automatic step(input string tag, input logic v, input logic [2:0] cls,
                        input logic cmp, input logic dpc, input logic hs,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] r, input logic [W-1:0] hi,
                        input logic sc, input logic [W-1:0] cur,
                        input logic [W-1:0] sav,
                        input logic [W-1:0] ew, input logic eu,
                        input logic er, input logic ewe);
        op_valid = v; op_class = cls; cmp_only = cmp; dest_pc = dpc;
        has_saved = hs; opnd_a = a; opnd_b = b; result = r; prod_hi = hi;
        shift_carry = sc; cur_status = cur; saved_status = sav;
        @(negedge clk);
        check(tag, {status_out, upd_valid, restore_pulse, reg_we}, {ew, eu, er, ewe});
        last_word = status_out;
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_class = 3'd0; cmp_only = 1'b0;
        dest_pc = 1'b0; has_saved = 1'b0; opnd_a = '0; opnd_b = '0;
        result = '0; prod_hi = '0; shift_carry = 1'b0;
        cur_status = '0; saved_status = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {status_out, upd_valid, restore_pulse, reg_we}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {status_out, upd_valid, restore_pulse, reg_we}, '0);

        // R2 / R3 / R8 / R9 exhaustive over operand pairs
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                for (int k = 0; k < 6; k++) begin
                    int cin, sa, sb, tot, st, cls, r;
                    logic c, v, cmp;
                    logic [W-1:0] cur;
                    string tag;
                    sa = (a >= 32) ? a - 64 : a;
                    sb = (b >= 32) ? b - 64 : b;
                    cin = (k == 2 || k == 3 || k == 5) ? 1 : 0;
                    cls = (k == 0) ? 0 : (k <= 2) ? 1 : (k == 3) ? 2 : 3;
                    if (k <= 2) begin
                        tot = a + b + cin;
                        c = (tot >= 64);
                        st = sa + sb + cin;
                        tag = "R2";
                    end else begin
                        tot = a - b - (1 - cin);
                        c = (tot >= 0);
                        st = sa - sb - (1 - cin);
                        tag = "R3";
                    end
                    r = tot & 63;
                    v = (st > 31) || (st < -32);
                    cur = 6'((a ^ (b * 5)) & 63);
                    cur[3] = cin[0];
                    cmp = 1'(b & 1);
                    step(tag, 1'b1, 3'(cls), cmp, 1'(a >> 1), 1'b0,
                         6'(a), 6'(b), 6'(r), 6'(a ^ b), 1'(k & 1), cur, 6'h2A,
                         {r[5], (r == 0), c, v, cur[1:0]}, 1'b1, 1'b0, ~cmp);
                end
            end
        end

        // R4 logical, R5 multiply
        for (int r = 0; r < 64; r++) begin
            for (int sc = 0; sc < 2; sc++) begin
                for (int fl = 0; fl < 16; fl++) begin
                    logic [W-1:0] cur;
                    logic [3:0] f4;
                    f4 = 4'(fl);
                    cur = {f4, 2'(r) ^ 2'b11};
                    step("R4", 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 6'(r ^ 21), 6'(r * 3),
                         6'(r), 6'(fl), 1'(sc), cur, 6'h15,
                         {r[5], (r == 0), 1'(sc), f4[0], cur[1:0]}, 1'b1, 1'b0, 1'b1);
                    step("R5", 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 6'(r * 7), 6'(fl),
                         6'(r), 6'(r ^ 63), 1'(sc), cur, 6'h15,
                         {r[5], (r == 0), f4[1], f4[0], cur[1:0]}, 1'b1, 1'b0, 1'b0);
                end
            end
        end

        // R6 long multiply
        for (int hi = 0; hi < 64; hi++) begin
            for (int lo = 0; lo < 64; lo++) begin
                logic [W-1:0] cur;
                logic [5:0] h6;
                h6 = 6'(hi);
                cur = 6'((hi * 11 + lo) & 63);
                step("R6", 1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 6'(lo), 6'(hi),
                     6'(lo), h6, h6[0], cur, 6'h3F,
                     {h6[5], (hi == 0 && lo == 0), cur[3], cur[2], cur[1:0]},
                     1'b1, 1'b0, 1'b1);
            end
        end

        // R11 no-change class
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] cur;
            cur = 6'(i * 13 + 5);
            step("R11", 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 6'h3F, 6'h01, 6'h00,
                 6'h00, 1'b1, cur, 6'h00, cur, 1'b1, 1'b0, 1'b1);
        end

        // R7 restore from saved word, flags from result must not leak
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] sav;
            sav = 6'(i * 9 + 3);
            step("R7", 1'b1, 3'(i), 1'(i & 1), 1'b1, 1'b1, 6'h3F, 6'h3F,
                 6'h00, 6'h00, 1'b1, 6'h00, sav, sav, 1'b1, 1'b1, ~1'(i & 1));
        end
        // R7 dest_pc without saved word: normal add update (31+1 = 32)
        step("R7", 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 6'd31, 6'd1, 6'd32, 6'd0,
             1'b0, 6'b000001, 6'h3F, 6'b100101, 1'b1, 1'b0, 1'b1);

        // R10 idle cycles hold the word
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] held;
            held = last_word;
            step("R10", 1'b0, 3'(i), 1'b0, 1'(i & 1), 1'b1, 6'(i), 6'(i),
                 6'(i), 6'(i), 1'b1, 6'(i * 5), 6'(i * 7), held, 1'b0, 1'b0, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule